// File: doc/BRIEF.md
# Bus Watchpoint Event Qualifier

This block observes one bus transaction per clock and decides whether it is a watchpoint hit. Three compare terms can qualify a transaction: a masked address compare, a check of the transaction type code against a programmable set of accepted codes, and a check of the current context ID against a programmed value. The context check can require either equality or inequality. Each compare term can be switched off independently so that it becomes a don't-care.

Software programs the block through a small register port. The port holds a control word, a reference address, an address mask, an accepted-type vector and a reference context. A master enable gates the whole function. When a transaction qualifies, the block raises a one-cycle event pulse on the following clock.

Top module: `bus_watchpoint`

## Requirements
- R1: After a synchronous active-low reset, the control register reads zero and no event is raised.
- R2: While the control enable (bit 0) is clear, no event is raised, whatever the compare results are.
- R3: With the address-ignore bit (bit 1) clear, an event requires that ((bus address XOR reference address) AND mask) equals zero.
- R4: With the address-ignore bit set, the bus address has no effect on detection.
- R5: With the type-ignore bit (bit 2) clear, an event requires that bit number `type code` of the 16-bit accepted-type vector is set.
- R6: With the type-ignore bit set, the type code has no effect on detection.
- R7: With only the context-equal bit (bit 3) set, an event requires that the bus context equals the reference context. When neither context bit is set, the context has no effect.
- R8: With only the context-differ bit (bit 4) set, an event requires that the bus context differs from the reference context.
- R9: With both context bits set, no event is ever raised.
- R10: The event output is registered. It is high for exactly one cycle, in the cycle after a qualifying transaction whose valid is high, and it never follows a cycle in which valid was low.
- R11: Register offsets are: 0 control, 1 reference address, 2 mask, 3 accepted-type vector, 4 reference context. Each register reads back what was written. Control bits 31:5 always read as zero.
- R12: A register write affects only transactions presented in later cycles. A transaction presented in the same cycle as the write is judged with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_addr | input | 32 | Transaction address |
| txn_type | input | 4 | Transaction type code |
| txn_ctx | input | 8 | Current context ID |
| wp_event | output | 1 | One-cycle watchpoint event pulse |

## Verification
On every cycle, the assertions check that an event is always backed by the previous cycle's state. That state includes the enable, the valid, the context mode conflict and each active compare term, together with the reset value of the control word. The assertions can only show that no false event occurs, so the bench must show that events do occur. A stimulus table covers the hit and miss cases for each compare term and each mode. Directed tests cover the single-cycle pulse width, register readback with reserved bits, and the timing of a write that lands in the same cycle as a transaction.

// File: rtl/wp_pkg.sv
// Package: shared constants and types for the bus watchpoint qualifier.
// Assumes: register offsets fit in a 3-bit register address.
package wp_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFF_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] OFF_ADDR  = 3'd1;
    localparam logic [REG_AW-1:0] OFF_MASK  = 3'd2;
    localparam logic [REG_AW-1:0] OFF_TYPES = 3'd3;
    localparam logic [REG_AW-1:0] OFF_CTX   = 3'd4;

    localparam int CTRL_W = 5;

    // Control word; the last field sits at bit 0.
    typedef struct packed {
        logic ctx_ne;   // bit 4: context must differ
        logic ctx_eq;   // bit 3: context must match
        logic typ_off;  // bit 2: ignore transaction type
        logic adr_off;  // bit 1: ignore address
        logic en;       // bit 0: master enable
    } wp_ctrl_t;

endpackage

// File: rtl/wp_regs.sv
// Module: wp_regs
// Holds the programmable state of the watchpoint: control word,
// reference address, address mask, accepted-type vector and reference
// context. Writes land on the clock edge; reads are combinational.
// Assumes ADDR_W, 2**TYPE_W and CTX_W are each no wider than DATA_W.
module wp_regs
    import wp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int TYPE_W = 4,
    parameter int CTX_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [REG_AW-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output wp_ctrl_t              ctrl,
    output logic [ADDR_W-1:0]     ref_addr,
    output logic [ADDR_W-1:0]     ref_mask,
    output logic [(1<<TYPE_W)-1:0] type_vec,
    output logic [CTX_W-1:0]      ref_ctx
);
    localparam int TV_W = 1 << TYPE_W;

    wp_ctrl_t              ctrl_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [ADDR_W-1:0]     mask_q;
    logic [TV_W-1:0]       types_q;
    logic [CTX_W-1:0]      ctx_q;

    // Register write path with synchronous reset to all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            addr_q  <= '0;
            mask_q  <= '0;
            types_q <= '0;
            ctx_q   <= '0;
        end else if (we) begin
            case (addr)
                OFF_CTRL:  ctrl_q  <= wp_ctrl_t'(wdata[CTRL_W-1:0]);
                OFF_ADDR:  addr_q  <= wdata[ADDR_W-1:0];
                OFF_MASK:  mask_q  <= wdata[ADDR_W-1:0];
                OFF_TYPES: types_q <= wdata[TV_W-1:0];
                OFF_CTX:   ctx_q   <= wdata[CTX_W-1:0];
                default:   ;
            endcase
        end
    end

    // Read mux; unused and reserved bits return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            OFF_CTRL:  rdata = DATA_W'(ctrl_q);
            OFF_ADDR:  rdata = DATA_W'(addr_q);
            OFF_MASK:  rdata = DATA_W'(mask_q);
            OFF_TYPES: rdata = DATA_W'(types_q);
            OFF_CTX:   rdata = DATA_W'(ctx_q);
            default:   rdata = '0;
        endcase
    end

    assign ctrl     = ctrl_q;
    assign ref_addr = addr_q;
    assign ref_mask = mask_q;
    assign type_vec = types_q;
    assign ref_ctx  = ctx_q;

    // R1: control word is zero in the first cycle after reset
    a_r1_ctrl_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_q == '0));

    // R11: reserved control bits never read back as one
    a_r11_ctrl_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFF_CTRL) |-> (rdata[DATA_W-1:CTRL_W] == '0));

endmodule

// File: rtl/wp_match.sv
// Module: wp_match
// Combinational qualification of one transaction against the programmed
// criteria. Produces a single hit bit; the master enable and the valid
// are folded in here, and registering is left to the parent.
// Assumes control fields follow wp_pkg::wp_ctrl_t.
module wp_match
    import wp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TYPE_W = 4,
    parameter int CTX_W  = 8
) (
    input  logic                   valid,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [TYPE_W-1:0]      bus_type,
    input  logic [CTX_W-1:0]       bus_ctx,
    input  wp_ctrl_t               ctrl,
    input  logic [ADDR_W-1:0]      ref_addr,
    input  logic [ADDR_W-1:0]      ref_mask,
    input  logic [(1<<TYPE_W)-1:0] type_vec,
    input  logic [CTX_W-1:0]       ref_ctx,
    output logic                   hit
);
    logic [ADDR_W-1:0] bit_diff;
    logic              addr_ok;
    logic              type_ok;
    logic              ctx_same;
    logic              ctx_ok;

    // Per-bit masked difference of the address compare.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_adiff
        assign bit_diff[i] = (bus_addr[i] ^ ref_addr[i]) & ref_mask[i];
    end

    // Address term: pass on a masked match or when the term is ignored.
    always_comb addr_ok = ctrl.adr_off || (bit_diff == '0);

    // Type term: the accepted-type vector is indexed by the incoming code.
    always_comb type_ok = ctrl.typ_off || type_vec[bus_type];

    // Context term: equal, differ, neither, or conflicting (blocks all).
    always_comb begin
        ctx_same = (bus_ctx == ref_ctx);
        case ({ctrl.ctx_ne, ctrl.ctx_eq})
            2'b00:   ctx_ok = 1'b1;
            2'b01:   ctx_ok = ctx_same;
            2'b10:   ctx_ok = !ctx_same;
            default: ctx_ok = 1'b0;
        endcase
    end

    // Final qualification of this cycle's transaction.
    always_comb hit = valid && ctrl.en && addr_ok && type_ok && ctx_ok;

endmodule

// File: rtl/bus_watchpoint.sv
// Module: bus_watchpoint (top)
// Watches one bus transaction per cycle and issues a one-cycle event
// pulse, registered, for each transaction that meets the programmed
// criteria. Assumes a single clock and a synchronous active-low reset.
module bus_watchpoint
    import wp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int TYPE_W = 4,
    parameter int CTX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              txn_valid,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [TYPE_W-1:0] txn_type,
    input  logic [CTX_W-1:0]  txn_ctx,
    output logic              wp_event
);
    localparam int TV_W = 1 << TYPE_W;

    wp_ctrl_t          ctrl;
    logic [ADDR_W-1:0] ref_addr;
    logic [ADDR_W-1:0] ref_mask;
    logic [TV_W-1:0]   type_vec;
    logic [CTX_W-1:0]  ref_ctx;
    logic              hit;
    logic              evt_q;

    wp_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .CTX_W(CTX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .ctrl     (ctrl),
        .ref_addr (ref_addr),
        .ref_mask (ref_mask),
        .type_vec (type_vec),
        .ref_ctx  (ref_ctx)
    );

    wp_match #(
        .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .CTX_W(CTX_W)
    ) u_match (
        .valid    (txn_valid),
        .bus_addr (txn_addr),
        .bus_type (txn_type),
        .bus_ctx  (txn_ctx),
        .ctrl     (ctrl),
        .ref_addr (ref_addr),
        .ref_mask (ref_mask),
        .type_vec (type_vec),
        .ref_ctx  (ref_ctx),
        .hit      (hit)
    );

    // Event register: one pulse per qualifying transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= hit;
    end

    assign wp_event = evt_q;

    // R2: an event needs the enable in the previous cycle
    a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(ctrl.en));

    // R10: an event needs a valid transaction in the previous cycle
    a_r10_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(txn_valid));

    // R9: conflicting context modes never yield an event
    a_r9_ctx_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> !$past(ctrl.ctx_eq && ctrl.ctx_ne));

    // R3: an active address term was satisfied
    a_r3_addr_term: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(ctrl.adr_off || (((txn_addr ^ ref_addr) & ref_mask) == '0)));

    // R5: an active type term was satisfied
    a_r5_type_term: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(ctrl.typ_off || type_vec[txn_type]));

    // R7: equal-context mode held on the event's transaction
    a_r7_ctx_equal: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(!ctrl.ctx_eq || (txn_ctx == ref_ctx)));

    // R8: differ-context mode held on the event's transaction
    a_r8_ctx_differ: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(!ctrl.ctx_ne || (txn_ctx != ref_ctx)));

endmodule

// File: tb/tb_bus_watchpoint.sv
module tb_bus_watchpoint;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        txn_valid;
    logic [31:0] txn_addr;
    logic [3:0]  txn_type;
    logic [7:0]  txn_ctx;
    logic        wp_event;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bus_watchpoint dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_type(txn_type),
        .txn_ctx(txn_ctx), .wp_event(wp_event)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [4:0]  ctrl;
        logic [31:0] baddr;
        logic [3:0]  btype;
        logic [7:0]  bctx;
        logic        exp;
    } vec_t;

    // Reference: address 0x1000_0000, mask 0xFFFF_F000, types {4}, context 5.
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{8'd3,  5'h01, 32'h1000_0123, 4'd4, 8'd5, 1'b1}, // R3 masked bits differ, hit
        '{8'd3,  5'h01, 32'h1000_1123, 4'd4, 8'd5, 1'b0}, // R3 compared bit differs
        '{8'd4,  5'h03, 32'h2000_0000, 4'd4, 8'd5, 1'b1}, // R4 address ignored
        '{8'd5,  5'h01, 32'h1000_0000, 4'd3, 8'd5, 1'b0}, // R5 type not accepted
        '{8'd5,  5'h01, 32'h1000_0000, 4'd4, 8'd9, 1'b1}, // R5 accepted, ctx ignored (R7 none)
        '{8'd6,  5'h05, 32'h1000_0000, 4'd3, 8'd5, 1'b1}, // R6 type ignored
        '{8'd7,  5'h09, 32'h1000_0000, 4'd4, 8'd5, 1'b1}, // R7 equal ctx
        '{8'd7,  5'h09, 32'h1000_0000, 4'd4, 8'd6, 1'b0}, // R7 ctx differs
        '{8'd8,  5'h11, 32'h1000_0000, 4'd4, 8'd6, 1'b1}, // R8 ctx differs
        '{8'd8,  5'h11, 32'h1000_0000, 4'd4, 8'd5, 1'b0}, // R8 ctx equal
        '{8'd9,  5'h19, 32'h1000_0000, 4'd4, 8'd5, 1'b0}, // R9 conflict
        '{8'd9,  5'h19, 32'h1000_0000, 4'd4, 8'd6, 1'b0}, // R9 conflict
        '{8'd9,  5'h1F, 32'h7777_0000, 4'd1, 8'd6, 1'b0}, // R9 conflict, terms off
        '{8'd2,  5'h06, 32'h1000_0000, 4'd4, 8'd5, 1'b0}, // R2 enable clear
        '{8'd4,  5'h07, 32'hDEAD_BEEF, 4'd0, 8'd0, 1'b1}  // R4/R6 all ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Presents one transaction, returns the event seen one cycle later.
    task automatic send(input logic [31:0] a, input logic [3:0] t,
                        input logic [7:0] c, output logic ev);
        @(negedge clk);
        txn_valid = 1'b1; txn_addr = a; txn_type = t; txn_ctx = c;
        @(posedge clk);
        @(negedge clk);
        txn_valid = 1'b0;
        ev = wp_event;
    endtask

    initial begin
        logic ev;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        txn_valid = 1'b0; txn_addr = '0; txn_type = '0; txn_ctx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        cfg_addr = 3'd0;
        #1 check("R1 ctrl reset", cfg_rdata, 32'h0);
        check("R1 event reset", {31'h0, wp_event}, 32'h0);

        // R11: readback and reserved bits
        reg_write(3'd0, 32'hFFFF_FFFF);
        cfg_addr = 3'd0; #1 check("R11 ctrl reserved", cfg_rdata, 32'h0000_001F);
        reg_write(3'd1, 32'h1000_0000);
        reg_write(3'd2, 32'hFFFF_F000);
        reg_write(3'd3, 32'h0000_0010);
        reg_write(3'd4, 32'h0000_0005);
        cfg_addr = 3'd1; #1 check("R11 addr readback", cfg_rdata, 32'h1000_0000);
        cfg_addr = 3'd2; #1 check("R11 mask readback", cfg_rdata, 32'hFFFF_F000);
        cfg_addr = 3'd3; #1 check("R11 types readback", cfg_rdata, 32'h0000_0010);
        cfg_addr = 3'd4; #1 check("R11 ctx readback", cfg_rdata, 32'h0000_0005);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            reg_write(3'd0, {27'h0, VEC[i].ctrl});
            send(VEC[i].baddr, VEC[i].btype, VEC[i].bctx, ev);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), {31'h0, ev}, {31'h0, VEC[i].exp});
        end

        // R10: pulse lasts one cycle; valid low gives no event
        reg_write(3'd0, 32'h1);
        send(32'h1000_0000, 4'd4, 8'd5, ev);
        check("R10 pulse high", {31'h0, ev}, 32'h1);
        @(negedge clk);
        check("R10 pulse one cycle", {31'h0, wp_event}, 32'h0);
        txn_addr = 32'h1000_0000; txn_type = 4'd4; txn_ctx = 8'd5; txn_valid = 1'b0;
        @(negedge clk);
        check("R10 valid low", {31'h0, wp_event}, 32'h0);

        // R10: back-to-back qualifying transactions give back-to-back pulses
        @(negedge clk);
        txn_valid = 1'b1;
        @(negedge clk);
        check("R10 back-to-back 1", {31'h0, wp_event}, 32'h1);
        @(negedge clk);
        txn_valid = 1'b0;
        check("R10 back-to-back 2", {31'h0, wp_event}, 32'h1);

        // R12: write in the same cycle as a transaction uses old values
        reg_write(3'd0, 32'h0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h1;
        txn_valid = 1'b1; txn_addr = 32'h1000_0000; txn_type = 4'd4; txn_ctx = 8'd5;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R12 same-cycle write", {31'h0, wp_event}, 32'h0);
        @(negedge clk);
        txn_valid = 1'b0;
        check("R12 next cycle new value", {31'h0, wp_event}, 32'h1);

        // R1: reset in mid-operation clears control and event
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cfg_addr = 3'd0;
        #1 check("R1 ctrl after reset", cfg_rdata, 32'h0);
        send(32'h1000_0000, 4'd4, 8'd5, ev);
        check("R1 no event after reset", {31'h0, ev}, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule